// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Event Interrupts

This block controls a bank of general-purpose pins from a simple word-wide register bus. Software picks each pin's direction, drives output values either by writing the full word or by setting and clearing chosen bits, and samples the input levels. Each input goes through a two-stage synchronizer before any logic uses it.

Each pin can report four kinds of event: a low level, a high level, a rising edge and a falling edge. Software enables each kind through its own per-pin mask, and a pin may have several kinds enabled at once. A matching event latches a bit in a sticky event register. Software clears that register by writing back the bits it wants cleared. A per-pin enable mask decides which latched bits drive the single combined interrupt output. Software changes that mask only through a set address and a clear address.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, all pins are inputs (direction register reads 0xFFFFFFFF). The output data, all four trigger masks, the interrupt enable mask, the event register and `irq` are all zero.
- R2: The direction register at byte address 0x134 reads back as written and drives `pad_oe_n`. A 1 bit makes the pin an input and a 0 bit makes it an output.
- R3: The output data register drives `pad_out` and is read at 0x13C. A write to 0x13C loads it. A write to 0x194 sets the bits written as 1, and a write to 0x190 clears them. Bits written as 0 at 0x190 or 0x194 keep their value.
- R4: Address 0x138 returns the pin levels after a two-flop synchronizer. A level applied to `pad_in` is readable there two clock edges later.
- R5: Writing 1s to 0x34 sets bits of the interrupt enable mask, and writing 1s to 0x38 clears them. Zero bits have no effect. Reading either address returns the mask.
- R6: Rising-edge mask (0x148) and falling-edge mask (0x14C): an enabled pin latches its event bit once when its synchronized level differs from its value one cycle earlier in the matching direction. An edge in the other direction latches nothing.
- R7: Low-level mask (0x140) and high-level mask (0x144): an enabled pin latches its event bit while its synchronized level matches. With both enabled on one pin, the bit is set on every cycle.
- R8: The event register at 0x2C is sticky and is set whatever the enable mask holds. A write there clears the bits written as 1 and leaves bits written as 0 unchanged.
- R9: If an event and a clearing write hit the same bit in the same cycle, the bit stays set. A level trigger that is still active keeps its bit set after a clearing write.
- R10: `irq` is the OR over all pins of (event bit AND enable bit), registered, so it follows the register state one cycle later.
- R11: Addresses 0x190 and 0x194 and unmapped addresses read as zero. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Driven output values |
| pad_oe_n | output | 32 | Per-pin direction, 1 = input |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach from the ports is an edge event that lands on the same clock edge as a clearing write to the same event bit. This only happens if the write arrives exactly three edges after the pad changes. The stimulus first latches the bit with an earlier edge, then moves the pad and issues the clearing write so it lands on the third edge, and expects the bit to survive. A second clear then shows that the edge event fires only once. The bench also enables both level triggers on one pin and moves the pad through both levels, expecting the bit to come back after every clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned NPINS  = 32;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_EVT_STAT = 12'h02C;
    localparam logic [ADDR_W-1:0] A_IEN_SET  = 12'h034;
    localparam logic [ADDR_W-1:0] A_IEN_CLR  = 12'h038;
    localparam logic [ADDR_W-1:0] A_OUT_CLR  = 12'h190;
    localparam logic [ADDR_W-1:0] A_OUT_SET  = 12'h194;
    localparam logic [ADDR_W-1:0] A_DIR      = 12'h134;
    localparam logic [ADDR_W-1:0] A_PIN_LVL  = 12'h138;
    localparam logic [ADDR_W-1:0] A_OUT_VAL  = 12'h13C;
    localparam logic [ADDR_W-1:0] A_TRG_LOW  = 12'h140;
    localparam logic [ADDR_W-1:0] A_TRG_HIGH = 12'h144;
    localparam logic [ADDR_W-1:0] A_TRG_RISE = 12'h148;
    localparam logic [ADDR_W-1:0] A_TRG_FALL = 12'h14C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_EVT,
        SEL_IEN_SET,
        SEL_IEN_CLR,
        SEL_DIR,
        SEL_PIN,
        SEL_OUT,
        SEL_TLOW,
        SEL_THIGH,
        SEL_TRISE,
        SEL_TFALL,
        SEL_OCLR,
        SEL_OSET
    } reg_sel_e;

    typedef struct packed {
        logic evt_clr;
        logic ien_set;
        logic ien_clr;
        logic dir;
        logic out_ld;
        logic out_clr;
        logic out_set;
        logic trg_low;
        logic trg_high;
        logic trg_rise;
        logic trg_fall;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_EVT_STAT: s = SEL_EVT;
            A_IEN_SET:  s = SEL_IEN_SET;
            A_IEN_CLR:  s = SEL_IEN_CLR;
            A_DIR:      s = SEL_DIR;
            A_PIN_LVL:  s = SEL_PIN;
            A_OUT_VAL:  s = SEL_OUT;
            A_TRG_LOW:  s = SEL_TLOW;
            A_TRG_HIGH: s = SEL_THIGH;
            A_TRG_RISE: s = SEL_TRISE;
            A_TRG_FALL: s = SEL_TFALL;
            A_OUT_CLR:  s = SEL_OCLR;
            A_OUT_SET:  s = SEL_OSET;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic pin_match(
        input logic lvl, input logic prev,
        input logic en_low, input logic en_high,
        input logic en_rise, input logic en_fall
    );
        return (en_low  & ~lvl)
             | (en_high &  lvl)
             | (en_rise &  lvl & ~prev)
             | (en_fall & ~lvl &  prev);
    endfunction

endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N  = NPINS,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  evt_stat,
    input  logic [N-1:0]  pin_lvl,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  ien_q,
    output logic [N-1:0]  tlow_q,
    output logic [N-1:0]  thigh_q,
    output logic [N-1:0]  trise_q,
    output logic [N-1:0]  tfall_q,
    output wr_strobe_t    stb,
    output logic [N-1:0]  rdata
);

    reg_sel_e sel;

    always_comb begin
        sel = decode_addr(addr);
        stb = '0;
        if (we) begin
            case (sel)
                SEL_EVT:     stb.evt_clr  = 1'b1;
                SEL_IEN_SET: stb.ien_set  = 1'b1;
                SEL_IEN_CLR: stb.ien_clr  = 1'b1;
                SEL_DIR:     stb.dir      = 1'b1;
                SEL_OUT:     stb.out_ld   = 1'b1;
                SEL_OCLR:    stb.out_clr  = 1'b1;
                SEL_OSET:    stb.out_set  = 1'b1;
                SEL_TLOW:    stb.trg_low  = 1'b1;
                SEL_THIGH:   stb.trg_high = 1'b1;
                SEL_TRISE:   stb.trg_rise = 1'b1;
                SEL_TFALL:   stb.trg_fall = 1'b1;
                default:     stb = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '1;
            out_q   <= '0;
            ien_q   <= '0;
            tlow_q  <= '0;
            thigh_q <= '0;
            trise_q <= '0;
            tfall_q <= '0;
        end else begin
            if (stb.dir)      dir_q   <= wdata;
            if (stb.out_ld)   out_q   <= wdata;
            else if (stb.out_set) out_q <= out_q | wdata;
            else if (stb.out_clr) out_q <= out_q & ~wdata;
            if (stb.ien_set)  ien_q   <= ien_q | wdata;
            else if (stb.ien_clr) ien_q <= ien_q & ~wdata;
            if (stb.trg_low)  tlow_q  <= wdata;
            if (stb.trg_high) thigh_q <= wdata;
            if (stb.trg_rise) trise_q <= wdata;
            if (stb.trg_fall) tfall_q <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_EVT:     rdata = evt_stat;
            SEL_IEN_SET: rdata = ien_q;
            SEL_IEN_CLR: rdata = ien_q;
            SEL_DIR:     rdata = dir_q;
            SEL_PIN:     rdata = pin_lvl;
            SEL_OUT:     rdata = out_q;
            SEL_TLOW:    rdata = tlow_q;
            SEL_THIGH:   rdata = thigh_q;
            SEL_TRISE:   rdata = trise_q;
            SEL_TFALL:   rdata = tfall_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned N      = gpio_irq_pkg::NPINS,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);

    localparam int unsigned LAST = STAGES - 1;

    logic [N-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain[s] <= '0;
                else if (s == 0) chain[s] <= pad_in;
                else             chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[LAST];
    end

    assign lvl = chain[LAST];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NPINS
) (
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] en_low,
    input  logic [N-1:0] en_high,
    input  logic [N-1:0] en_rise,
    input  logic [N-1:0] en_fall,
    output logic [N-1:0] evt
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            assign evt[i] = pin_match(lvl[i], prev[i], en_low[i],
                                      en_high[i], en_rise[i], en_fall[i]);
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int unsigned N = gpio_irq_pkg::NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] ien,
    output logic [N-1:0] stat_q,
    output logic         irq_q
);

    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~clr_eff) | evt;
            irq_q  <= |(stat_q & ien);
        end
    end

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NP = NPINS,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [NP-1:0] bus_wdata,
    output logic [NP-1:0] bus_rdata,
    input  logic [NP-1:0] pad_in,
    output logic [NP-1:0] pad_out,
    output logic [NP-1:0] pad_oe_n,
    output logic          irq
);

    logic [NP-1:0] lvl, prev, evt, stat_q;
    logic [NP-1:0] dir_q, out_q, ien_q;
    logic [NP-1:0] tlow_q, thigh_q, trise_q, tfall_q;
    wr_strobe_t    stb;

    gpio_pin_sync #(.N(NP), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .lvl    (lvl),
        .prev   (prev)
    );

    gpio_reg_bank #(.N(NP), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .evt_stat (stat_q),
        .pin_lvl  (lvl),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .ien_q    (ien_q),
        .tlow_q   (tlow_q),
        .thigh_q  (thigh_q),
        .trise_q  (trise_q),
        .tfall_q  (tfall_q),
        .stb      (stb),
        .rdata    (bus_rdata)
    );

    gpio_trig_detect #(.N(NP)) u_trig (
        .lvl     (lvl),
        .prev    (prev),
        .en_low  (tlow_q),
        .en_high (thigh_q),
        .en_rise (trise_q),
        .en_fall (tfall_q),
        .evt     (evt)
    );

    gpio_irq_ctrl #(.N(NP)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_we   (stb.evt_clr),
        .clr_mask (bus_wdata),
        .ien      (ien_q),
        .stat_q   (stat_q),
        .irq_q    (irq)
    );

    assign pad_out  = out_q;
    assign pad_oe_n = dir_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NPINS
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] bus_wdata,
    input wr_strobe_t   stb,
    input logic [N-1:0] stat_q,
    input logic [N-1:0] ien_q,
    input logic [N-1:0] out_q,
    input logic [N-1:0] dir_q,
    input logic         irq
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '1 && out_q == '0 && ien_q == '0
                        && stat_q == '0 && !irq));

    // R8
    sticky_evt_chk: assert property (@(posedge clk) disable iff (rst)
        !stb.evt_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R5
    ien_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb.ien_set && !stb.ien_clr) |=> $stable(ien_q));

    // R3
    out_set_chk: assert property (@(posedge clk) disable iff (rst)
        stb.out_set |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq == $past(|(stat_q & ien_q))));

endmodule

bind gpio_irq_top gpio_irq_chk #(.N(NP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wdata (bus_wdata),
    .stb       (stb),
    .stat_q    (stat_q),
    .ien_q     (ien_q),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .irq       (irq)
);

// File: tb/gpio_irq_top_test.sv
module gpio_irq_top_test;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe_n;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef enum int {K_RD, K_IRQ, K_POUT, K_POE} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  mon_ev;

    always #10 clk = ~clk;

    gpio_irq_top uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe_n  (pad_oe_n),
        .irq       (irq)
    );

    initial begin : monitor
        forever begin
            item_t it;
            logic [31:0] act;
            @(mon_ev);
            #2;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {31'b0, irq};
                K_POUT:  act = pad_out;
                default: act = pad_oe_n;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input kind_e k, input logic [31:0] e, input string t);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.tag  = t;
        q.push_back(it);
        ->mon_ev;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        push(K_RD, e, t);
    endtask

    task automatic look(input kind_e k, input logic [31:0] e, input string t);
        @(negedge clk);
        push(k, e, t);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic pad_set(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin : driver
        idle(5);
        rst = 1'b0;

        // R1 reset state
        rd(A_DIR, 32'hFFFF_FFFF, "R1 dir");
        rd(A_OUT_VAL, 32'h0, "R1 out");
        rd(A_EVT_STAT, 32'h0, "R1 stat");
        rd(A_IEN_SET, 32'h0, "R1 ien");
        rd(A_TRG_RISE, 32'h0, "R1 trig");
        look(K_IRQ, 32'h0, "R1 irq");
        look(K_POE, 32'hFFFF_FFFF, "R1 oe");

        // R2 direction
        wr(A_DIR, 32'h0000_FFFF);
        rd(A_DIR, 32'h0000_FFFF, "R2 dir readback");
        look(K_POE, 32'h0000_FFFF, "R2 pad_oe_n");

        // R3 output data
        wr(A_OUT_VAL, 32'h1234_5678);
        rd(A_OUT_VAL, 32'h1234_5678, "R3 load");
        wr(A_OUT_SET, 32'hF000_0000);
        rd(A_OUT_VAL, 32'hF234_5678, "R3 set");
        wr(A_OUT_CLR, 32'h0000_000F);
        rd(A_OUT_VAL, 32'hF234_5670, "R3 clear");
        wr(A_OUT_SET, 32'h0);
        look(K_POUT, 32'hF234_5670, "R3 zero set no effect");

        // R11 read-as-zero and unmapped writes
        rd(A_OUT_SET, 32'h0, "R11 set addr reads zero");
        rd(12'h000, 32'h0, "R11 unmapped read");
        wr(12'h004, 32'hDEAD_BEEF);
        rd(A_DIR, 32'h0000_FFFF, "R11 unmapped write ignored");

        // R4 input sampling
        pad_set(32'hA5A5_0F0F);
        idle(3);
        rd(A_PIN_LVL, 32'hA5A5_0F0F, "R4 pin levels");
        pad_set(32'h0);
        idle(3);
        rd(A_EVT_STAT, 32'h0, "R8 no trigger no event");

        // R6 rising edge on pin 3
        wr(A_TRG_RISE, 32'h8);
        pad_set(32'h8);
        idle(3);
        rd(A_EVT_STAT, 32'h8, "R6 rising latched");
        pad_set(32'h0);
        idle(3);
        rd(A_EVT_STAT, 32'h8, "R8 sticky after fall");
        wr(A_EVT_STAT, 32'h8);
        rd(A_EVT_STAT, 32'h0, "R8 w1c");

        // R6 falling edge on pin 7
        wr(A_TRG_FALL, 32'h80);
        pad_set(32'h80);
        idle(3);
        rd(A_EVT_STAT, 32'h0, "R6 rise ignored on fall pin");
        pad_set(32'h0);
        idle(3);
        rd(A_EVT_STAT, 32'h80, "R6 falling latched");
        wr(A_EVT_STAT, 32'h0);
        rd(A_EVT_STAT, 32'h80, "R8 zero write no effect");
        wr(A_EVT_STAT, 32'h80);
        rd(A_EVT_STAT, 32'h0, "R8 clear fall");

        // R7 high level on pin 10
        wr(A_TRG_HIGH, 32'h400);
        pad_set(32'h400);
        idle(3);
        rd(A_EVT_STAT, 32'h400, "R7 high level");
        wr(A_EVT_STAT, 32'h400);
        rd(A_EVT_STAT, 32'h400, "R9 active level re-sets");
        pad_set(32'h0);
        idle(3);
        wr(A_EVT_STAT, 32'h400);
        rd(A_EVT_STAT, 32'h0, "R7 level gone clears");
        wr(A_TRG_HIGH, 32'h0);

        // R7 low level and both levels on pin 12
        wr(A_TRG_LOW, 32'h1000);
        idle(3);
        rd(A_EVT_STAT, 32'h1000, "R7 low level");
        wr(A_TRG_HIGH, 32'h1000);
        pad_set(32'h1000);
        idle(3);
        wr(A_EVT_STAT, 32'h1000);
        rd(A_EVT_STAT, 32'h1000, "R7 both levels pad high");
        pad_set(32'h0);
        idle(3);
        wr(A_EVT_STAT, 32'h1000);
        rd(A_EVT_STAT, 32'h1000, "R7 both levels pad low");
        wr(A_TRG_LOW, 32'h0);
        wr(A_TRG_HIGH, 32'h0);
        wr(A_EVT_STAT, 32'h1000);
        rd(A_EVT_STAT, 32'h0, "R7 both cleared");

        // R5 / R10 enable and interrupt
        wr(A_IEN_SET, 32'h8);
        rd(A_IEN_SET, 32'h8, "R5 set readback");
        rd(A_IEN_CLR, 32'h8, "R5 clear addr readback");
        look(K_IRQ, 32'h0, "R10 idle");
        pad_set(32'h8);
        idle(4);
        look(K_IRQ, 32'h1, "R10 irq on enabled event");
        wr(A_EVT_STAT, 32'h8);
        look(K_IRQ, 32'h0, "R10 irq drops after clear");
        pad_set(32'h80);
        idle(3);
        pad_set(32'h0);
        idle(4);
        rd(A_EVT_STAT, 32'h80, "R8 latched while disabled");
        look(K_IRQ, 32'h0, "R10 masked");
        wr(A_IEN_SET, 32'h80);
        idle(1);
        look(K_IRQ, 32'h1, "R10 irq after enable");
        wr(A_IEN_CLR, 32'h8);
        rd(A_IEN_SET, 32'h80, "R5 clear one bit");
        wr(A_IEN_CLR, 32'h80);
        idle(1);
        look(K_IRQ, 32'h0, "R10 irq after disable");
        rd(A_EVT_STAT, 32'h80, "R8 status kept when disabled");
        wr(A_EVT_STAT, 32'h80);

        // R9 edge event collides with clearing write on pin 20
        wr(A_TRG_RISE, 32'h0010_0008);
        pad_set(32'h0010_0000);
        idle(3);
        rd(A_EVT_STAT, 32'h0010_0000, "R6 pin20 rising");
        pad_set(32'h0);
        idle(2);
        pad_set(32'h0010_0000);
        @(negedge clk);
        wr(A_EVT_STAT, 32'h0010_0000);
        rd(A_EVT_STAT, 32'h0010_0000, "R9 set wins over clear");
        wr(A_EVT_STAT, 32'h0010_0000);
        rd(A_EVT_STAT, 32'h0, "R6 edge is one-shot");

        idle(3);
        if (!done) begin
            done = 1'b1;
            summary();
        end
    end

endmodule